// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Port with Fault Flags

This block is an 8-bit serial peripheral port that acts as either the clock master or a clocked slave. A bit in the control register picks the role. Software sees three byte-wide locations on a simple register bus:

- **Control** holds the enable, the role, the clock polarity and phase, and a rate selector.
- **Status** holds three flags: transfer complete, write collision and mode fault.
- **Data** reads back the receive buffer. Writing it loads the shift register.

Every transfer is full duplex and moves the most significant bit first. On the same clock that a bit leaves, the incoming bit enters the shift register. When the eighth bit has entered, the shift register is copied into the receive buffer. This gives a second receive stage, so software can read one byte while the next is shifting. The transmit side has no second stage. A data write that arrives while a byte is in flight is dropped and only raises the collision flag.

In the master role, a data write starts a transfer. The block makes eight clock pulses from the system clock and leaves the serial clock at its rest level before and after them. In the slave role, the external select and serial clock are brought into the system clock domain through two flip-flops each. Shifting then follows the edges of the external clock. If the select input goes low while the block is master, the mode-fault flag is set, the role bit falls back to slave, and the clock and data-out drivers are released until software clears the fault.

The register bus is plain control traffic and has no back-pressure: an access with `bus_sel` high completes in its cycle. Read data is combinational from the selected register. A read has a side effect in the cycle it is presented.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, and `sck_oe`, `mosi_oe` and `miso_oe` are all low.
- R2: In the master role, a data write while idle yields exactly eight pulses on `sck_o`. Before the first pulse and after the last, `sck_o` sits at the polarity bit.
- R3: In the master role, each half period of `sck_o` lasts 1, 2, 8 or 16 system clocks for rate code 0, 1, 2 or 3 in control bits [5:4].
- R4: A transfer sends the written byte most significant bit first. The byte gathered from the serial input, most significant bit first, becomes readable at the data address.
- R5: When the eighth bit is received, the received byte is copied to the receive buffer and status bit 0 (transfer complete) is set.
- R6: A data write during a transfer is dropped, leaves the byte in flight unchanged, and sets status bit 1 (write collision).
- R7: Status bits 0 and 1 clear only when a status read that saw them set is followed by an access to the data address.
- R8: In the master role (control bit 1 set, bit 0 enable set), a low select input sets status bit 2 (mode fault), clears control bit 1, and holds `sck_oe` and `mosi_oe` low.
- R9: Status bit 2 clears only when a status read that saw it set is followed by a control write. A control write without that read leaves it set.
- R10: With phase bit (control bit 3) at 0, the first bit is on the data output as soon as the transfer starts. Input is sampled on each leading clock edge and the output moves on each trailing edge.
- R11: With phase bit 1, the output moves on leading edges after the first, and input is sampled on trailing edges.
- R12: In the slave role, a data write only loads the shift register. Bits leave on `miso_o` only as the external clock arrives, and `miso_oe` is high only while select is low.
- R13: In the slave role with phase 0, after a byte completes, further clock edges are ignored until select returns high. A new byte starts on the next select fall.
- R14: In the slave role with phase 1, select may stay low across successive bytes, and each group of eight clocks completes one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe for one cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| ss_n_i | input | 1 | Active-low select input |
| sck_i | input | 1 | Serial clock input, used in the slave role |
| sck_o | output | 1 | Serial clock output in the master role |
| sck_oe | output | 1 | Drive enable for the serial clock |
| mosi_i | input | 1 | Serial data in for the slave role |
| mosi_o | output | 1 | Serial data out in the master role |
| mosi_oe | output | 1 | Drive enable for master data out |
| miso_i | input | 1 | Serial data in for the master role |
| miso_o | output | 1 | Serial data out in the slave role |
| miso_oe | output | 1 | Drive enable for slave data out |

## Verification
The bench builds the block at its default 8-bit data width and steps through all four rate codes. This makes the one-clock half period, where leading and trailing edges fall on consecutive cycles, and the sixteen-clock half period, which leaves room for a mid-transfer data write, both reachable. All four polarity and phase pairs are driven in the master role. In the slave role the bench paces the external clock at ten system clocks per half period, which stays clear of the two-flop input delay. That slow pacing is what makes the ignored trailing pulses of phase 0 and the back-to-back phase-1 bytes observable.

// File: rtl/spi_dp_pkg.sv
package spi_dp_pkg;
  localparam int HALF_W = 5;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] code);
    case (code)
      2'd0:    half_period = HALF_W'(1);
      2'd1:    half_period = HALF_W'(2);
      2'd2:    half_period = HALF_W'(8);
      default: half_period = HALF_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/spi_dp_sync.sv
module spi_dp_sync #(
  parameter logic RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_dp_clkgen.sv
module spi_dp_clkgen
  import spi_dp_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       cpol,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       lead,
  output logic       trail,
  output logic       busy
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);

  logic [HALF_W-1:0] cnt;
  logic [EW-1:0]     edge_n;
  logic [HALF_W-1:0] half;
  logic              tick;

  assign half  = half_period(rate);
  assign tick  = busy && (cnt == half - HALF_W'(1));
  assign lead  = tick && !edge_n[0];
  assign trail = tick && edge_n[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      edge_n <= '0;
      sck    <= 1'b0;
    end else if (abort) begin
      busy   <= 1'b0;
      cnt    <= '0;
      edge_n <= '0;
      sck    <= cpol;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      edge_n <= '0;
      sck    <= cpol;
    end else if (busy) begin
      if (tick) begin
        cnt    <= '0;
        sck    <= ~sck;
        edge_n <= edge_n + EW'(1);
        if (edge_n == EW'(EDGES - 1)) busy <= 1'b0;
      end else begin
        cnt <= cnt + HALF_W'(1);
      end
    end else begin
      sck <= cpol;
    end
  end

  // R2: the clock is back at its rest level once the last edge is made
  assert_rest_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && edge_n == EW'(EDGES - 1) && !abort) |=> (!busy && sck == $past(cpol)));
endmodule

// File: rtl/spi_dp_shifter.sv
module spi_dp_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  input  logic            restart,
  input  logic            lead,
  input  logic            trail,
  input  logic            cpha,
  input  logic            din,
  output logic            dout,
  output logic            done,
  output logic [BITS-1:0] word_in
);
  localparam int CW = $clog2(BITS);

  logic [BITS-1:0] sreg;
  logic [CW-1:0]   cnt;
  logic            rx_bit;
  logic            last;
  logic            in_bit;

  assign last    = (cnt == CW'(BITS - 1));
  assign in_bit  = cpha ? din : rx_bit;
  assign word_in = {sreg[BITS-2:0], in_bit};
  assign done    = trail && last;
  assign dout    = sreg[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      cnt    <= '0;
      rx_bit <= 1'b0;
    end else if (load) begin
      sreg <= load_val;
      cnt  <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else begin
      if (lead) begin
        if (!cpha)            rx_bit <= din;
        else if (cnt != '0)   sreg   <= {sreg[BITS-2:0], rx_bit};
      end
      if (trail) begin
        if (!cpha) begin
          sreg <= word_in;
        end else begin
          rx_bit <= din;
          if (last) sreg <= word_in;
        end
        cnt <= last ? '0 : cnt + CW'(1);
      end
    end
  end

  // R11: with phase 1 the output never moves on a sampling (trailing) edge except the closing one
  assert_phase1_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpha && trail && !last && !load && !restart) |=> $stable(dout));
endmodule

// File: rtl/spi_dp_flags.sv
module spi_dp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic ctrl_wr,
  input  logic done_set,
  input  logic wcol_set,
  input  logic modf_set,
  output logic done_f,
  output logic wcol_f,
  output logic modf_f
);
  logic done_arm, wcol_arm, modf_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f   <= 1'b0;
      wcol_f   <= 1'b0;
      modf_f   <= 1'b0;
      done_arm <= 1'b0;
      wcol_arm <= 1'b0;
      modf_arm <= 1'b0;
    end else begin
      if (done_set)                    done_f <= 1'b1;
      else if (data_acc && done_arm)   done_f <= 1'b0;
      if (wcol_set)                    wcol_f <= 1'b1;
      else if (data_acc && wcol_arm)   wcol_f <= 1'b0;
      if (modf_set)                    modf_f <= 1'b1;
      else if (ctrl_wr && modf_arm)    modf_f <= 1'b0;

      if (data_acc)                    done_arm <= 1'b0;
      else if (stat_rd && done_f)      done_arm <= 1'b1;
      if (data_acc)                    wcol_arm <= 1'b0;
      else if (stat_rd && wcol_f)      wcol_arm <= 1'b1;
      if (ctrl_wr)                     modf_arm <= 1'b0;
      else if (stat_rd && modf_f)      modf_arm <= 1'b1;
    end
  end

  // R5: completion always leaves the flag set
  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_f);
  // R7: completion and collision flags drop only through a data access
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_f) |-> $past(data_acc));
  assert_wcol_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wcol_f) |-> $past(data_acc));
  // R9: the fault flag drops only through a control write
  assert_modf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modf_f) |-> $past(ctrl_wr));
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_dp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ss_n_i,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe
);
  ctrl_t         ctrl;
  logic [DW-1:0] rx_buf;

  // register bus decode
  logic ctrl_wr, stat_rd, data_acc, data_wr;
  assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign stat_rd  = bus_sel && !bus_wr && (bus_addr == A_STAT);
  assign data_acc = bus_sel && (bus_addr == A_DATA);
  assign data_wr  = data_acc && bus_wr;

  // external pins into the system clock domain
  logic ss_s, sck_s, ss_q, sck_q;
  spi_dp_sync #(.RST(1'b1)) u_ss_sync  (.clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_s));
  spi_dp_sync #(.RST(1'b0)) u_sck_sync (.clk(clk), .rst_n(rst_n), .d(sck_i),  .q(sck_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      ss_q  <= ss_s;
      sck_q <= sck_s;
    end
  end

  logic is_master, slave_sel;
  logic done_f, wcol_f, modf_f;
  assign is_master = ctrl.en && ctrl.master;
  assign slave_sel = ctrl.en && !ctrl.master && !ss_s;

  // master clocking
  logic m_start, m_abort, m_sck, m_lead, m_trail, m_busy;
  logic modf_set, s_busy, busy;
  assign modf_set = is_master && !ss_s;
  assign busy     = is_master ? m_busy : s_busy;
  assign m_start  = data_wr && is_master && !m_busy && !modf_f;
  assign m_abort  = modf_set || ctrl_wr;

  spi_dp_clkgen #(.BITS(DW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(m_start), .abort(m_abort),
    .cpol(ctrl.cpol), .rate(ctrl.rate), .sck(m_sck),
    .lead(m_lead), .trail(m_trail), .busy(m_busy)
  );

  // slave edge qualification
  logic sck_edge, lead_s, trail_s, ss_fall, s_hold, s_start, sl_lead, sl_trail;
  assign sck_edge = sck_s != sck_q;
  assign lead_s   = sck_edge && (sck_s != ctrl.cpol);
  assign trail_s  = sck_edge && (sck_s == ctrl.cpol);
  assign ss_fall  = !ss_s && ss_q;
  assign s_start  = slave_sel && !s_busy && !s_hold && (ctrl.cpha ? lead_s : ss_fall);
  assign sl_lead  = slave_sel && lead_s && (s_busy || s_start);
  assign sl_trail = slave_sel && trail_s && s_busy;

  // shift datapath shared by both roles
  logic          sh_done, sh_dout;
  logic [DW-1:0] sh_word;
  spi_dp_shifter #(.BITS(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(data_wr && !busy), .load_val(bus_wdata),
    .restart(m_start || s_start),
    .lead(is_master ? m_lead : sl_lead),
    .trail(is_master ? m_trail : sl_trail),
    .cpha(ctrl.cpha),
    .din(is_master ? miso_i : mosi_i),
    .dout(sh_dout), .done(sh_done), .word_in(sh_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_busy <= 1'b0;
      s_hold <= 1'b0;
    end else begin
      if (!slave_sel || sh_done) s_busy <= 1'b0;
      else if (s_start)          s_busy <= 1'b1;
      if (ss_s)                                     s_hold <= 1'b0;
      else if (sh_done && !is_master && !ctrl.cpha) s_hold <= 1'b1;
    end
  end

  // control register and receive buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[5:0]);
      if (modf_set) ctrl.master <= 1'b0;
      if (sh_done) rx_buf <= sh_word;
    end
  end

  spi_dp_flags u_flags (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_acc(data_acc),
    .ctrl_wr(ctrl_wr), .done_set(sh_done), .wcol_set(data_wr && busy),
    .modf_set(modf_set), .done_f(done_f), .wcol_f(wcol_f), .modf_f(modf_f)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[5:0] = ctrl;
      A_STAT:  bus_rdata[2:0] = {modf_f, wcol_f, done_f};
      A_DATA:  bus_rdata      = rx_buf;
      default: bus_rdata      = '0;
    endcase
  end

  assign sck_o   = m_sck;
  assign sck_oe  = is_master && !modf_f;
  assign mosi_o  = sh_dout;
  assign mosi_oe = is_master && !modf_f;
  assign miso_o  = sh_dout;
  assign miso_oe = slave_sel;

  // R1: a disabled block drives none of its pins
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !(sck_oe || mosi_oe || miso_oe));
  // R2: the clock generator stops exactly when the byte completes
  assert_eight_pulses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(m_busy) && !$past(m_abort) && $past(is_master)) |-> $past(sh_done));
  // R5: the receive buffer takes the completed word
  assert_rx_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> (rx_buf == $past(sh_word)));
  // R6: a write during a transfer raises the collision flag
  assert_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol_f);
  // R8: a fault forces the block out of the master role with drivers off
  assert_fault_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    modf_set |=> (modf_f && !ctrl.master && !sck_oe && !mosi_oe));
endmodule

// File: tb/tb_spi_duplex_port.sv
`timescale 1ns/1ps
module tb_spi_duplex_port;
  import spi_dp_pkg::*;

  localparam real CLK_P = 4.0;
  localparam int  SH    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic ss_n_i = 1, sck_i = 0, mosi_i = 0, miso_i = 0;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_duplex_port #(.DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_n_i(ss_n_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  logic [7:0] last_stat;
  task automatic wait_done(input string tag);
    int n = 0;
    last_stat = 0;
    while (!last_stat[0] && n < 3000) begin
      bus_read(A_STAT, last_stat);
      n++;
    end
    chk({tag, " completion flag"}, last_stat[0], 1'b1);
  endtask

  // ---------------- scoreboard: remote slave model for master runs
  logic [7:0] exp_q[$];
  bit model_on = 0, m_cpol, m_cpha, bad_half;
  logic [7:0] reply, cap;
  int lead_n, trail_n, cap_n, edges_n, m_half;
  realtime last_t;
  logic mosi_seen;

  always @(negedge clk) mosi_seen = mosi_o;

  task automatic capture_bit();
    cap = {cap[6:0], mosi_seen};
    cap_n++;
    if (cap_n == 8) begin
      if (exp_q.size() == 0) chk("R4 unexpected byte on mosi", cap, 8'hxx);
      else chk("R4 byte shifted out msb first", cap, exp_q.pop_front());
    end
  endtask

  always @(sck_o) begin
    if (model_on) begin
      if (edges_n > 0 && ($realtime - last_t) != m_half * CLK_P) bad_half = 1;
      last_t = $realtime;
      edges_n++;
      if (sck_o != m_cpol) begin
        lead_n++;
        if (!m_cpha) capture_bit();
        else if (lead_n <= 8) miso_i = reply[8 - lead_n];
      end else begin
        trail_n++;
        if (m_cpha) capture_bit();
        else if (trail_n < 8) miso_i = reply[7 - trail_n];
      end
    end
  end

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] rep, input logic cpol,
                        input logic cpha, input logic [1:0] rate, input int half);
    logic [7:0] got;
    bus_write(A_CTRL, {2'b00, rate, cpha, cpol, 1'b1, 1'b1});
    repeat (3) @(negedge clk);
    m_cpol = cpol; m_cpha = cpha; m_half = half; reply = rep;
    lead_n = 0; trail_n = 0; cap_n = 0; edges_n = 0; bad_half = 0; cap = 0;
    miso_i = rep[7];
    model_on = 1;
    exp_q.push_back(tx);
    bus_write(A_DATA, tx);
    chk("R2 sck at rest before first pulse", sck_o, cpol);
    if (!cpha) chk("R10 first bit driven at start", mosi_o, tx[7]);
    wait_done("R5");
    repeat (2) @(negedge clk);
    chk("R2 leading edge count", lead_n, 8);
    chk("R2 trailing edge count", trail_n, 8);
    chk("R2 sck back at rest", sck_o, cpol);
    chk("R3 half period length", bad_half, 0);
    bus_read(A_DATA, got);
    chk(cpha ? "R11 received byte" : "R10 received byte", got, rep);
    model_on = 0;
  endtask

  // ---------------- bench acting as master for slave runs
  task automatic s_bits(input logic [7:0] tx, input logic cpha, input logic cpol,
                        output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = tx[i];
        repeat (SH) @(negedge clk);
        got[i] = miso_o;
        sck_i = ~cpol;
        repeat (SH) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = tx[i];
        repeat (SH) @(negedge clk);
        got[i] = miso_o;
        sck_i = cpol;
        repeat (SH) @(negedge clk);
      end
    end
    repeat (SH) @(negedge clk);
  endtask

  initial begin
    #(200000 * CLK_P);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_read(A_CTRL, r); chk("R1 control after reset", r, 8'h00);
    bus_read(A_STAT, r); chk("R1 status after reset", r, 8'h00);
    chk("R1 drive enables after reset", {sck_oe, mosi_oe, miso_oe}, 3'b000);

    // master runs over all polarity/phase pairs and rate codes
    m_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 2'd1, 2);
    bus_read(A_STAT, r); chk("R7 flags cleared by status then data", r, 8'h00);
    m_xfer(8'h81, 8'h7E, 1'b1, 1'b1, 2'd0, 1);
    m_xfer(8'h6B, 8'hD2, 1'b0, 1'b1, 2'd2, 8);
    m_xfer(8'h0F, 8'hF1, 1'b1, 1'b0, 2'd3, 16);

    // R6 write collision during a slow transfer
    bus_write(A_CTRL, {2'b00, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1});
    repeat (3) @(negedge clk);
    m_cpol = 0; m_cpha = 0; m_half = 16; reply = 8'h99;
    lead_n = 0; trail_n = 0; cap_n = 0; edges_n = 0; bad_half = 0;
    miso_i = 1'b1; model_on = 1;
    exp_q.push_back(8'hC3);
    bus_write(A_DATA, 8'hC3);
    repeat (40) @(negedge clk);
    bus_write(A_DATA, 8'h55);
    wait_done("R6");
    chk("R6 collision flag set", last_stat[1], 1'b1);
    repeat (2) @(negedge clk);
    chk("R6 transfer length unchanged", lead_n, 8);
    bus_read(A_DATA, got);
    chk("R6 received byte intact", got, 8'h99);
    model_on = 0;
    bus_read(A_STAT, r); chk("R7 both flags cleared", r, 8'h00);

    // R8 / R9 mode fault
    bus_write(A_CTRL, 8'h03);
    ss_n_i = 0;
    repeat (5) @(negedge clk);
    chk("R8 drivers released", {sck_oe, mosi_oe}, 2'b00);
    bus_read(A_CTRL, r); chk("R8 master bit cleared", r[1], 1'b0);
    ss_n_i = 1;
    repeat (4) @(negedge clk);
    bus_write(A_CTRL, 8'h03);
    chk("R8 drivers stay off while fault set", sck_oe, 1'b0);
    bus_read(A_STAT, r); chk("R9 fault kept without prior status read", r[2], 1'b1);
    bus_write(A_CTRL, 8'h03);
    bus_read(A_STAT, r); chk("R9 fault cleared by status then control", r[2], 1'b0);
    chk("R9 drivers back after clear", sck_oe, 1'b1);

    // R12 / R13 slave, phase 0
    bus_write(A_CTRL, 8'h01);
    bus_write(A_DATA, 8'h3C);
    repeat (SH) @(negedge clk);
    chk("R12 miso not driven while deselected", miso_oe, 1'b0);
    ss_n_i = 0;
    repeat (SH) @(negedge clk);
    chk("R12 miso driven while selected", miso_oe, 1'b1);
    bus_read(A_STAT, r); chk("R12 nothing shifts without clock", r[0], 1'b0);
    s_bits(8'hA6, 1'b0, 1'b0, got);
    chk("R12 slave sent loaded byte", got, 8'h3C);
    wait_done("R12");
    bus_read(A_DATA, r); chk("R12 slave received byte", r, 8'hA6);
    s_bits(8'h11, 1'b0, 1'b0, got);
    bus_read(A_STAT, r); chk("R13 clocks ignored before select release", r[0], 1'b0);
    bus_read(A_DATA, r); chk("R13 buffer unchanged", r, 8'hA6);
    ss_n_i = 1;
    repeat (SH) @(negedge clk);
    bus_write(A_DATA, 8'h5A);
    ss_n_i = 0;
    repeat (SH) @(negedge clk);
    s_bits(8'hC1, 1'b0, 1'b0, got);
    chk("R13 next byte after select toggle sent", got, 8'h5A);
    wait_done("R13");
    bus_read(A_DATA, r); chk("R13 next byte received", r, 8'hC1);
    ss_n_i = 1;
    repeat (SH) @(negedge clk);

    // R14 slave, phase 1, polarity 1, select held low
    sck_i = 1;
    repeat (SH) @(negedge clk);
    bus_write(A_CTRL, 8'h0D);
    bus_write(A_DATA, 8'hA5);
    ss_n_i = 0;
    repeat (SH) @(negedge clk);
    s_bits(8'h96, 1'b1, 1'b1, got);
    chk("R14 first byte sent", got, 8'hA5);
    wait_done("R14");
    bus_read(A_DATA, r); chk("R14 first byte received", r, 8'h96);
    bus_write(A_DATA, 8'h5A);
    s_bits(8'h0F, 1'b1, 1'b1, got);
    chk("R14 second byte sent with select low", got, 8'h5A);
    wait_done("R14");
    bus_read(A_DATA, r); chk("R14 second byte received", r, 8'h0F);
    ss_n_i = 1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule